// File: doc/BRIEF.md
# Dual Downcounter Watchdog Timer

This block holds two free-running downcounters that share one control and status register: a periodic real-time counter and a software watchdog. Each counter reloads from its own period register whenever it passes through zero. Each time it does, it latches a sticky zero flag. Software can only clear a flag by first reading it as set and then writing a zero to that bit. This prevents a blind write from discarding a timeout that was never observed.

A watchdog timeout either pulses a reset request or raises an interrupt. The real-time timeout raises an interrupt only when its enable bit is set. Both interrupts share one 3-bit priority level. The watchdog can be told to keep counting or to freeze when the chip enters low-power stop. A freeze holds until the next reset.

Top module: `dual_wdt_timer`

## Requirements
- R1: Writing a value P to the real-time period register (address 1) loads the counter with P. The counter then decrements once per clock. The real-time zero flag (control bit 6) becomes 1 exactly P+1 clock edges after the write edge, and the cycle repeats every P+1 cycles.
- R2: Writing P to the watchdog period register (address 2) behaves in the same way for the watchdog. The watchdog zero flag is control bit 7.
- R3: A zero flag is cleared only by a write to address 0 carrying 0 in that bit, after a read strobe of address 0 that returned the bit as 1, with no other address-0 write in between. A write of 0 with no such read leaves the flag set. A write of 1 never sets a flag. Reading with no read strobe arms nothing.
- R4: When the watchdog mode bit (control bit 4) is 0, each watchdog timeout drives `rst_req` high for one cycle, in the same cycle in which the watchdog flag becomes 1.
- R5: When the watchdog mode bit is 1, a watchdog timeout produces no reset request. While the watchdog flag is set, `irq_level` equals the level field (control bits 2:0).
- R6: When the real-time interrupt enable bit (control bit 3) is 0, a set real-time flag does not drive `irq_level`. When the bit is 1, `irq_level` shows the level field while that flag is set.
- R7: A level field of 0 keeps `irq_level` at 0 whatever is pending. `irq_level` returns to 0 once every enabled pending flag is cleared.
- R8: When the stop-count select bit (control bit 5) is 1, the watchdog keeps counting while `lp_stop` is high. When that bit is 0 and `lp_stop` is high, the watchdog freezes. It stays frozen, even after `lp_stop` falls, until `rst_n` is applied.
- R9: After reset, the control bits, both flags, `rst_req` and `irq_level` are 0. The period registers read back their parameter defaults, 999 and 4095. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 control/status, 1 real-time period, 2 watchdog period |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; arms flag clearing |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| lp_stop | input | 1 | Low-power stop indication |
| rst_req | output | 1 | One-cycle reset request on watchdog timeout |
| irq_level | output | 3 | Pending interrupt level, 0 when none |

## Verification
The hardest state to reach is a flag that is armed and then disarmed, or a flag that is set while no counter keeps re-setting it. The bench reaches it by first running a counter with a short period. It then parks that counter on the maximum period, so the flag stays stable while the read/write sequences are tried. The frozen watchdog can only be seen through `rst_req`. For that reason the bench programs a short period and counts reset pulses over fixed windows: with stop counting enabled, then while stopped, after stop ends, and after a reset.

// File: rtl/dwt_pkg.sv
// Shared register map and control layout for the dual downcounter timer.
// Assumes a data bus at least 8 bits wide.
package dwt_pkg;
    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_RTPER = 2'd1;
    localparam logic [1:0] ADDR_WDPER = 2'd2;
    localparam int         CTRL_BITS  = 6;
    localparam int         FLAG_LSB   = 6;   // bit 6 real-time flag, bit 7 watchdog flag
    localparam int         NUM_FLAGS  = 2;

    typedef struct packed {
        logic       wd_run_in_stop; // bit 5
        logic       wd_irq_mode;    // bit 4: 1 interrupt, 0 reset
        logic       rt_irq_en;      // bit 3
        logic [2:0] level;          // bits 2:0
    } ctrl_t;
endpackage

// File: rtl/dwt_downcounter.sv
// Reloadable downcounter with its own period register.
// A load writes both the period and the count. While run is high the
// counter decrements and, on passing zero, reloads the period and flags an event.
module dwt_downcounter #(
    parameter int          W          = 16,
    parameter logic [W-1:0] RST_PERIOD = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic [W-1:0] period_o,
    output logic         zero_evt
);
    logic [W-1:0] period_q;
    logic [W-1:0] cnt_q;

    // Period register and count: load has priority, otherwise count when running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= RST_PERIOD;
            cnt_q    <= RST_PERIOD;
        end else if (load) begin
            period_q <= load_val;
            cnt_q    <= load_val;
        end else if (run) begin
            cnt_q <= (cnt_q == '0) ? period_q : cnt_q - 1'b1;
        end
    end

    // Timeout event: the running counter sits at zero this cycle.
    always_comb zero_evt = run && !load && (cnt_q == '0);

    assign period_o = period_q;
endmodule

// File: rtl/dwt_zero_flag.sv
// Sticky zero flag with read-then-write-zero clearing.
// Assumes rd_ctrl and wr_ctrl are strobes already qualified by address 0.
module dwt_zero_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic rd_ctrl,
    input  logic wr_ctrl,
    input  logic wbit,
    output logic flag
);
    logic armed_q;

    // Flag: a set event wins; otherwise an armed write of 0 clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                          flag <= 1'b0;
        else if (set_evt)                    flag <= 1'b1;
        else if (wr_ctrl && armed_q && !wbit) flag <= 1'b0;
    end

    // Arm: a read that sees the flag set arms it; any control write disarms it.
    always_ff @(posedge clk) begin
        if (!rst_n)                armed_q <= 1'b0;
        else if (wr_ctrl)          armed_q <= 1'b0;
        else if (rd_ctrl && flag)  armed_q <= 1'b1;
    end

    assert_flag_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag); // also covers R2 for the watchdog instance

    assert_flag_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(wr_ctrl && armed_q && !wbit));
endmodule

// File: rtl/dual_wdt_timer.sv
// Dual downcounter timer: a real-time counter and a watchdog sharing one
// control/status register, one interrupt level and sticky zero flags.
// Assumes DATA_W >= 8. No prescaler: each counter steps once per clock.
module dual_wdt_timer
    import dwt_pkg::*;
#(
    parameter int               DATA_W    = 16,
    parameter logic [DATA_W-1:0] RT_PER_RST = 16'd999,
    parameter logic [DATA_W-1:0] WD_PER_RST = 16'd4095
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              lp_stop,
    output logic              rst_req,
    output logic [2:0]        irq_level
);
    localparam int PAD_W = DATA_W - CTRL_BITS - NUM_FLAGS;

    ctrl_t              ctrl_q;
    logic               wd_frozen_q;
    logic               stop_hold;
    logic               rt_evt, wd_evt;
    logic [DATA_W-1:0]  rt_period, wd_period;
    logic [NUM_FLAGS-1:0] evt_vec, flag_vec;
    logic               wr_ctrl, rd_ctrl;
    logic               pending;

    always_comb wr_ctrl   = reg_wr && (reg_addr == ADDR_CTRL);
    always_comb rd_ctrl   = reg_rd && (reg_addr == ADDR_CTRL);
    always_comb stop_hold = lp_stop && !ctrl_q.wd_run_in_stop;

    // Control bits: written as a whole at address 0.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata[CTRL_BITS-1:0]);
    end

    // Freeze latch: once stop freezes the watchdog, only reset releases it.
    always_ff @(posedge clk) begin
        if (!rst_n)         wd_frozen_q <= 1'b0;
        else if (stop_hold) wd_frozen_q <= 1'b1;
    end

    dwt_downcounter #(.W(DATA_W), .RST_PERIOD(RT_PER_RST)) u_rt_cnt (
        .clk(clk), .rst_n(rst_n),
        .load(reg_wr && (reg_addr == ADDR_RTPER)), .load_val(reg_wdata),
        .run(1'b1), .period_o(rt_period), .zero_evt(rt_evt)
    );

    dwt_downcounter #(.W(DATA_W), .RST_PERIOD(WD_PER_RST)) u_wd_cnt (
        .clk(clk), .rst_n(rst_n),
        .load(reg_wr && (reg_addr == ADDR_WDPER)), .load_val(reg_wdata),
        .run(!wd_frozen_q && !stop_hold), .period_o(wd_period), .zero_evt(wd_evt)
    );

    always_comb evt_vec = {wd_evt, rt_evt};

    // One sticky flag per counter, laid out from FLAG_LSB upward.
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        dwt_zero_flag u_flag (
            .clk(clk), .rst_n(rst_n), .set_evt(evt_vec[i]),
            .rd_ctrl(rd_ctrl), .wr_ctrl(wr_ctrl),
            .wbit(reg_wdata[FLAG_LSB+i]), .flag(flag_vec[i])
        );
    end

    // Reset request: one registered pulse per watchdog timeout in reset mode.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= wd_evt && !ctrl_q.wd_irq_mode;
    end

    // Interrupt level: shared priority while any enabled flag is pending.
    always_comb begin
        pending   = (flag_vec[0] && ctrl_q.rt_irq_en) || (flag_vec[1] && ctrl_q.wd_irq_mode);
        irq_level = pending ? ctrl_q.level : 3'd0;
    end

    // Read mux: combinational view of the addressed register.
    always_comb begin
        case (reg_addr)
            ADDR_CTRL:  reg_rdata = {{PAD_W{1'b0}}, flag_vec, ctrl_q};
            ADDR_RTPER: reg_rdata = rt_period;
            ADDR_WDPER: reg_rdata = wd_period;
            default:    reg_rdata = '0;
        endcase
    end

    assert_rst_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(wd_evt && !ctrl_q.wd_irq_mode));

    assert_irq_needs_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != 3'd0) |-> (flag_vec != '0));

    assert_frozen_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wd_frozen_q |-> !wd_evt);
endmodule

// File: tb/dual_wdt_timer_bench.sv
module dual_wdt_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        lp_stop = 1'b0;
    logic        rst_req;
    logic [2:0]  irq_level;
    int checks = 0, fails = 0;
    logic [5:0]  ctrl_sh = '0;
    logic [15:0] v;

    always #4 clk = ~clk;

    dual_wdt_timer u_dual_wdt_timer (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lp_stop(lp_stop), .rst_req(rst_req), .irq_level(irq_level)
    );

    function automatic logic [2:0] exp_irq(logic [5:0] c, logic rtf, logic wdf);
        logic pend;
        pend = (rtf && c[3]) || (wdf && c[4]);
        return pend ? c[2:0] : 3'd0;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [15:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic peek(logic [1:0] a, output logic [15:0] d);
        reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic wctrl(logic [5:0] c);  // flag bits written as 1: never clears
        ctrl_sh = c; wr(2'd0, {8'h00, 2'b11, c});
    endtask

    task automatic clear_flags();
        logic [15:0] t;
        rd(2'd0, t); wr(2'd0, {8'h00, 2'b00, ctrl_sh});
    endtask

    task automatic count_rst(int n, output int cnt);
        cnt = 0;
        for (int k = 0; k < n; k++) begin @(negedge clk); #1 if (rst_req) cnt++; end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; repeat (4) @(negedge clk); rst_n = 1'b1; ctrl_sh = '0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int n;
        logic [15:0] p;
        void'($urandom(32'd20240611));
        do_reset();
        // R9 reset values
        peek(2'd0, v); chk("R9 ctrl", v, 0);
        peek(2'd1, v); chk("R9 rt period", v, 999);
        peek(2'd2, v); chk("R9 wd period", v, 4095);
        peek(2'd3, v); chk("R9 addr3", v, 0);
        chk("R9 rst_req", rst_req, 0);
        chk("R9 irq", irq_level, 0);

        // R1 / R2: random periods, exact timeout cycle
        for (int w = 0; w < 2; w++) begin
            for (int it = 0; it < 6; it++) begin
                p = 16'(2 + $urandom % 40);
                wr(2'd1, 16'hFFFF); wr(2'd2, 16'hFFFF);
                clear_flags();
                wr(w ? 2'd2 : 2'd1, p);
                repeat (p) @(negedge clk);
                peek(2'd0, v); chk(w ? "R2 before" : "R1 before", v[6+w], 0);
                @(negedge clk);
                peek(2'd0, v); chk(w ? "R2 at" : "R1 at", v[6+w], 1);
            end
        end

        // R3: flag clear protocol (rt flag set, counters parked)
        wr(2'd1, 16'hFFFF); wr(2'd2, 16'hFFFF); clear_flags();
        wr(2'd0, {8'h00, 2'b01, ctrl_sh});
        peek(2'd0, v); chk("R3 write 1 no set", v[6], 0);
        wr(2'd1, 16'd3); repeat (6) @(negedge clk); wr(2'd1, 16'hFFFF);
        wr(2'd0, {8'h00, 2'b00, ctrl_sh});
        peek(2'd0, v); chk("R3 blind write 0 keeps", v[6], 1);
        rd(2'd0, v); wr(2'd0, {8'h00, 2'b11, ctrl_sh}); wr(2'd0, {8'h00, 2'b00, ctrl_sh});
        peek(2'd0, v); chk("R3 disarmed by write", v[6], 1);
        rd(2'd0, v); chk("R3 read sees 1", v[6], 1);
        wr(2'd0, {8'h00, 2'b00, ctrl_sh});
        peek(2'd0, v); chk("R3 read then write 0 clears", v[6], 0);

        // R4: reset-mode pulses, period 5 -> every 6 cycles
        wctrl(6'b000_000);
        wr(2'd2, 16'd5);
        repeat (5) @(negedge clk); #1 chk("R4 no early pulse", rst_req, 0);
        @(negedge clk); #1 chk("R4 pulse at timeout", rst_req, 1);
        @(negedge clk); #1 chk("R4 one cycle", rst_req, 0);
        peek(2'd0, v); chk("R4 wd flag", v[7], 1);
        wr(2'd2, 16'd5); count_rst(20, n); chk("R4 pulse count", n, 3);

        // R5: interrupt mode
        wctrl(6'b010_110);
        count_rst(20, n); chk("R5 no reset in irq mode", n, 0);
        chk("R5 irq level", irq_level, 6);

        // R6 / R7 / R5 random: park counters with both flags set
        wr(2'd1, 16'd2); wr(2'd2, 16'd2); repeat (6) @(negedge clk);
        wr(2'd1, 16'hFFFF); wr(2'd2, 16'hFFFF);
        wctrl(6'b000_101);
        #1 chk("R6 rt disabled", irq_level, 0);
        wctrl(6'b001_101);
        #1 chk("R6 rt enabled", irq_level, 5);
        wctrl(6'b011_000);
        #1 chk("R7 level zero", irq_level, 0);
        for (int it = 0; it < 10; it++) begin
            logic [5:0] c;
            c = 6'($urandom) & 6'b011_111;
            wctrl(c);
            #1 chk("R5 R6 R7 random", irq_level, exp_irq(c, 1'b1, 1'b1));
        end
        wctrl(6'b011_011);
        clear_flags();
        #1 chk("R7 cleared", irq_level, 0);

        // R8: counting through stop, then freeze until reset
        wctrl(6'b100_000);
        lp_stop = 1'b1;
        wr(2'd2, 16'd3); count_rst(16, n); chk("R8 counts in stop", n, 4);
        wctrl(6'b000_000);
        repeat (4) @(negedge clk);
        count_rst(20, n); chk("R8 frozen in stop", n, 0);
        lp_stop = 1'b0;
        count_rst(20, n); chk("R8 stays frozen", n, 0);
        do_reset();
        chk("R9 irq after reset", irq_level, 0);
        wr(2'd2, 16'd3); count_rst(16, n); chk("R8 resumes after reset", n, 4);

        summary();
    end
endmodule